// File: doc/BRIEF.md
# Control-Pin Programming Mode Detector

This block watches a shared control pin once per start-up. It decides whether the pin will carry a duty-cycle dimming waveform or single-wire serial commands. The first low-to-high transition after shutdown opens a timed detection window. A qualifying long low pulse inside that window selects serial mode at once. If the window runs out without one, the default duty-cycle mode is chosen. The choice is then frozen until the power sequencer signals a shutdown.

All timing is counted in ticks of a one-microsecond strobe, `us_tick`. The pin input is expected to be synchronized to `clk` already. Both outputs are plain control pins and carry no handshake. `mode_serial` holds the latched choice. `mode_valid` is a single-cycle strobe that marks the moment of decision. The window length, the arming delay and the minimum low time are parameters (defaults 1000, 100 and 260 ticks).

Top module: `ctrl_mode_detect`

## Requirements
- R1: After reset, `mode_serial` and `mode_valid` are 0. A pin that is already high at reset does not open a window; only a low-to-high transition does.
- R2: The window starts in the cycle of the first rising edge seen while idle, with its tick count at 0. The count advances only in cycles where `us_tick` is 1.
- R3: A falling edge starts a low-time measurement only if the window tick count before that edge is at least `DELAY_US`. A low that began earlier is never counted, even if it lasts past the delay.
- R4: Serial mode (`mode_serial`=1) is chosen on the tick at which the measured low time reaches `LOW_US`+1 ticks. The tick of the falling edge itself counts as 1. The choice is made immediately, without waiting for the window to end.
- R5: Each qualifying falling edge restarts the low-time count, and a rising edge ends the measurement.
- R6: On the tick at which the window count reaches `WIN_US`, duty-cycle mode (`mode_serial`=0) is chosen, unless a serial qualification falls on that same tick; in that case serial wins.
- R7: `mode_valid` is 1 for exactly one clock, in the cycle after the deciding edge, and at most once per start-up.
- R8: After a decision, further pin activity changes neither output until a shutdown.
- R9: `shutdown` is synchronous. In the following cycle `mode_serial` and `mode_valid` are 0 and the block waits for a new rising edge. A shutdown during an open window abandons it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_pin | input | 1 | Synchronized control pin level |
| us_tick | input | 1 | One-microsecond timing strobe |
| shutdown | input | 1 | Shutdown indication from sequencer |
| mode_serial | output | 1 | Latched mode: 1 serial, 0 duty-cycle |
| mode_valid | output | 1 | One-cycle strobe when the mode is decided |

## Verification
The bench builds the block with `DELAY_US`=4, `LOW_US`=6 and `WIN_US`=20. With these values every boundary falls within about twenty ticks. These boundaries are an edge just before and just at arming, a low one tick short of qualifying, and a qualification that lands on the very tick the window closes. Each pin pattern is stepped one tick at a time. The tick index of the decision is compared with a value worked out by hand, so an off-by-one in any counter moves the strobe visibly.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_LOCKED = 2'd2
  } det_state_t;
endpackage

// File: rtl/cmd_edge.sv
module cmd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic pin_q;

  // Resets high so a pin held high from reset does not look like a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin;
  end

  assign rise = pin & ~pin_q;
  assign fall = ~pin & pin_q;
endmodule

// File: rtl/cmd_win_timer.sv
module cmd_win_timer #(
  parameter int WIN_US   = 1000,
  parameter int DELAY_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic armed,
  output logic expire
);
  localparam int CW = $clog2(WIN_US + 1);
  localparam logic [CW-1:0] LAST  = CW'(WIN_US - 1);
  localparam logic [CW-1:0] ARMAT = CW'(DELAY_US);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt <= '0;
    else if (clear)                              cnt <= '0;
    else if (run && tick && cnt != CW'(WIN_US))  cnt <= cnt + 1'b1;
  end

  assign armed  = (cnt >= ARMAT);
  assign expire = run & tick & (cnt == LAST);
endmodule

// File: rtl/cmd_low_timer.sv
module cmd_low_timer #(
  parameter int LOW_US = 260
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  input  logic stop,
  input  logic pin,
  input  logic tick,
  output logic qualify
);
  localparam int LW = $clog2(LOW_US + 2);
  localparam logic [LW-1:0] LIMIT = LW'(LOW_US);

  logic          measuring;
  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      measuring <= 1'b0;
      cnt       <= '0;
    end else if (clear) begin
      measuring <= 1'b0;
      cnt       <= '0;
    end else if (start) begin
      measuring <= 1'b1;
      cnt       <= tick ? LW'(1) : '0;
    end else if (stop) begin
      measuring <= 1'b0;
    end else if (measuring && tick && !pin && cnt <= LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  // True on the tick that takes the low time past the limit.
  assign qualify = measuring & ~pin & tick & (cnt == LIMIT);
endmodule

// File: rtl/ctrl_mode_detect.sv
module ctrl_mode_detect
  import cmd_pkg::*;
#(
  parameter int DELAY_US = 100,
  parameter int LOW_US   = 260,
  parameter int WIN_US   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_pin,
  input  logic us_tick,
  input  logic shutdown,
  output logic mode_serial,
  output logic mode_valid
);
  det_state_t state;
  logic rise, fall, armed, expire, qualify;
  logic in_win, tmr_clear;

  assign in_win    = (state == ST_WINDOW);
  assign tmr_clear = !in_win || shutdown;

  cmd_edge u_edge (
    .clk (clk), .rst_n (rst_n), .pin (ctrl_pin),
    .rise (rise), .fall (fall)
  );

  cmd_win_timer #(.WIN_US(WIN_US), .DELAY_US(DELAY_US)) u_win (
    .clk (clk), .rst_n (rst_n), .clear (tmr_clear), .run (in_win),
    .tick (us_tick), .armed (armed), .expire (expire)
  );

  cmd_low_timer #(.LOW_US(LOW_US)) u_low (
    .clk (clk), .rst_n (rst_n), .clear (tmr_clear),
    .start (in_win && fall && armed), .stop (rise),
    .pin (ctrl_pin), .tick (us_tick), .qualify (qualify)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mode_serial <= 1'b0;
      mode_valid  <= 1'b0;
    end else if (shutdown) begin
      state       <= ST_IDLE;
      mode_serial <= 1'b0;
      mode_valid  <= 1'b0;
    end else begin
      mode_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (rise) state <= ST_WINDOW;
        ST_WINDOW: begin
          if (qualify) begin
            mode_serial <= 1'b1;
            mode_valid  <= 1'b1;
            state       <= ST_LOCKED;
          end else if (expire) begin
            mode_serial <= 1'b0;
            mode_valid  <= 1'b1;
            state       <= ST_LOCKED;
          end
        end
        ST_LOCKED: state <= ST_LOCKED;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_checker.sv
module cmd_checker (
  input logic clk,
  input logic rst_n,
  input logic ctrl_pin,
  input logic us_tick,
  input logic shutdown,
  input logic mode_serial,
  input logic mode_valid
);
  logic decided;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          decided <= 1'b0;
    else if (shutdown)   decided <= 1'b0;
    else if (mode_valid) decided <= 1'b1;
  end

  assert_strobe_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> !mode_valid);

  assert_once_per_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> !decided);

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown |=> (mode_valid || $stable(mode_serial)));

  assert_decide_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_valid) |-> $past(us_tick));

  assert_serial_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && mode_serial) |-> $past(!ctrl_pin));

  assert_shutdown_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (!mode_serial && !mode_valid));
endmodule

bind ctrl_mode_detect cmd_checker u_cmd_checker (
  .clk (clk), .rst_n (rst_n), .ctrl_pin (ctrl_pin), .us_tick (us_tick),
  .shutdown (shutdown), .mode_serial (mode_serial), .mode_valid (mode_valid)
);

// File: tb/ctrl_mode_detect_bench.sv
`timescale 1ns/1ps
module ctrl_mode_detect_bench;
  localparam int DLY = 4;
  localparam int LOW = 6;
  localparam int WIN = 20;
  localparam int NV  = 7;

  // {high_ticks, low1, high2, low2, expect_serial, expect_index}
  localparam logic [7:0] VEC [NV][6] = '{
    '{8'd5,  8'd8,  8'd0, 8'd0, 8'd1, 8'd11},
    '{8'd4,  8'd10, 8'd0, 8'd0, 8'd0, 8'd20},
    '{8'd5,  8'd6,  8'd0, 8'd0, 8'd0, 8'd20},
    '{8'd14, 8'd7,  8'd0, 8'd0, 8'd1, 8'd20},
    '{8'd15, 8'd7,  8'd0, 8'd0, 8'd0, 8'd20},
    '{8'd5,  8'd3,  8'd2, 8'd8, 8'd1, 8'd16},
    '{8'd3,  8'd10, 8'd0, 8'd0, 8'd0, 8'd20}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_pin = 1'b1;
  logic us_tick = 1'b0;
  logic shutdown = 1'b0;
  logic mode_serial, mode_valid;

  int checks = 0, errors = 0;
  int idx, vcount, vidx, extra;
  logic vser;

  always #10 clk = ~clk;

  ctrl_mode_detect #(.DELAY_US(DLY), .LOW_US(LOW), .WIN_US(WIN)) u_ctrl_mode_detect (
    .clk (clk), .rst_n (rst_n), .ctrl_pin (ctrl_pin), .us_tick (us_tick),
    .shutdown (shutdown), .mode_serial (mode_serial), .mode_valid (mode_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts and ends on a falling clock edge; one tick per step.
  task automatic step(input logic p);
    ctrl_pin = p;
    us_tick  = 1'b1;
    @(negedge clk);
    if (mode_valid) begin vcount++; vidx = idx; vser = mode_serial; end
    us_tick = 1'b0;
    @(negedge clk);
    if (mode_valid) extra++;
    idx++;
  endtask

  task automatic clear_rec();
    idx = 0; vcount = 0; vidx = -1; extra = 0; vser = 1'b0;
  endtask

  task automatic do_shutdown();
    shutdown = 1'b1;
    @(negedge clk);
    shutdown = 1'b0;
    check("R9 mode cleared", mode_serial, 0);
    check("R9 strobe cleared", mode_valid, 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values, and pin high since reset opens nothing
    check("R1 mode after reset", mode_serial, 0);
    check("R1 strobe after reset", mode_valid, 0);
    clear_rec();
    for (int i = 0; i < 30; i++) step(1'b1);
    check("R1 no decision without rising edge", vcount, 0);

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      do_shutdown();
      for (int i = 0; i < 3; i++) step(1'b0);
      clear_rec();
      for (int i = 0; i < int'(VEC[v][0]); i++) step(1'b1);
      for (int i = 0; i < int'(VEC[v][1]); i++) step(1'b0);
      for (int i = 0; i < int'(VEC[v][2]); i++) step(1'b1);
      for (int i = 0; i < int'(VEC[v][3]); i++) step(1'b0);
      while (idx < 30) step(1'b1);
      check($sformatf("R7 vec%0d one decision", v), vcount, 1);
      check($sformatf("R7 vec%0d strobe one cycle", v), extra, 0);
      check($sformatf("R4 R6 vec%0d mode", v), int'(vser), int'(VEC[v][4]));
      check($sformatf("R3 R5 vec%0d decision tick", v), vidx, int'(VEC[v][5]));
      // R8: further activity ignored
      clear_rec();
      for (int i = 0; i < 12; i++) step(1'b0);
      for (int i = 0; i < 25; i++) step(1'b1);
      check($sformatf("R8 vec%0d no new decision", v), vcount + extra, 0);
      check($sformatf("R8 vec%0d mode held", v), int'(mode_serial), int'(VEC[v][4]));
    end

    // R9: shutdown after serial lock clears the mode
    do_shutdown();

    // R2: idle cycles without ticks do not advance the window
    for (int i = 0; i < 3; i++) step(1'b0);
    clear_rec();
    step(1'b1);
    repeat (100) @(negedge clk);
    while (idx < 30) step(1'b1);
    check("R2 tick gating decision tick", vidx, 20);
    check("R2 tick gating mode", int'(vser), 0);

    // R9: shutdown mid-window abandons it
    do_shutdown();
    for (int i = 0; i < 3; i++) step(1'b0);
    clear_rec();
    for (int i = 0; i < 5; i++) step(1'b1);
    do_shutdown();
    clear_rec();
    for (int i = 0; i < 30; i++) step(1'b1);
    check("R9 aborted window no decision", vcount, 0);
    check("R9 aborted window mode", mode_serial, 0);

    // R9: fresh start-up after abort still works
    for (int i = 0; i < 3; i++) step(1'b0);
    clear_rec();
    for (int i = 0; i < 5; i++) step(1'b1);
    for (int i = 0; i < 8; i++) step(1'b0);
    while (idx < 30) step(1'b1);
    check("R9 restart serial decision", int'(vser), 1);
    check("R9 restart decision tick", vidx, 11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule